// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of independent power domains on and off under software control. Every domain sits in its own 128-byte window of a simple register bus, with windows stacked contiguously from address zero. Software writes a target state into the domain's command word. The domain's sequencer then walks the gate outputs through an ordered series of steps: power switches, isolation, clock and reset. Programmable waits separate the steps.

Progress is reported in a status word. A busy flag is high while a sequence runs. A completion flag is sticky and software clears it by writing a one to it. A two-bit field gives the domain's present state. A gate-status word mirrors the live reset, clock and isolation outputs, and a switch-status word shows the acknowledge lines returned by the power switches.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Domain k answers at byte addresses k*0x80 to k*0x80+0x7F, using the low 7 bits as the register offset and word-aligned accesses only. A read of an address past the last domain returns 0, and a write to one domain changes no register of another domain.
- R2: After reset, every status word reads 0x0002_0000: state field bits 17:16 = 2 (off), busy bit 3 = 0, completion bit 1 = 0. All reset, clock-enable, isolation-release and switch outputs are 0.
- R3: Writing the word 1 (on) or 2 (off) to offset 0x20 requests that state. Any other written value is ignored, and the status stays unchanged.
- R4: With S = effective switch delay (offset 0x14) and O = effective on delay (offset 0x1C), an accepted power-up works as follows, counting edges from the accepting edge, which is edge 0. The switch outputs take the on mask (offset 0x0C) at edge 0. Isolation is released at edge S. The clock is enabled at edge S+O. Reset is released at edge S+O+1, and at that same edge the state becomes 1, busy clears and completion sets. Busy is high between these points.
- R5: With F = effective off delay (offset 0x18), an accepted power-down works as follows. Reset is asserted at edge 0. The clock is disabled at edge 1. Isolation is applied at edge 1+F. At edge 1+F+S the switch outputs take the off mask (offset 0x10), the state becomes 2, busy clears and completion sets.
- R6: The completion flag stays set until a write to the status word (offset 0x24) has bit 1 set. A status write with bit 1 clear leaves it set.
- R7: A command equal to the current state sets completion at the accepting edge, does not raise busy and leaves all gate outputs unchanged.
- R8: A command written while busy is ignored; the running sequence completes with its original timing and target.
- R9: Delay registers count controller clock cycles; a value of 0 behaves as a 1-cycle wait and a value N>0 as N cycles.
- R10: Configuration registers read back what was written. Offset 0x30 reads bit 0 = reset released, bit 1 = clock enabled, bit 2 = isolation released. Offset 0x34 reads the switch acknowledge inputs.
- R11: Bit 0 of offsets 0x00 (reset), 0x04 (clock) and 0x08 (isolation) are step enables, each 1 after reset. A step whose enable is 0 leaves its output inactive after power-up.
- R12: Domains operate independently; a sequence in one domain does not change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with bus_en |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dom_rst_n | output | NUM_DOM | Per-domain reset, low = held in reset |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso_rel | output | NUM_DOM | Per-domain isolation release, high = outputs pass |
| dom_psw_en | output | NUM_DOM*PSW_W | Per-domain power-switch enables |
| dom_psw_ack | input | NUM_DOM*PSW_W | Per-domain power-switch acknowledges |

## Verification
The assertions take for granted that software keeps to the status handshake. They also assume that only the sequencer moves the gate outputs, so reset is released only after a power-up, and isolation is released only while a power-up is in flight and the state still reads off. The stimulus stays within this: every command is issued while busy is low, except one directed case that writes mid-sequence on purpose, and the step enables are left at 1 apart from a single enable-clear case. Random delays stay in 0 to 5 and random masks in range, so every sequence completes well inside the run.

// File: rtl/pwr_seq_pkg.sv
// Package: shared constants for the power domain sequencing controller.
// Assumes 32-bit register words and 128-byte domain windows.
package pwr_seq_pkg;
    localparam logic [1:0] ST_ON  = 2'd1;
    localparam logic [1:0] ST_OFF = 2'd2;

    localparam int WIN_BITS = 7;

    // word indices (byte offset / 4) inside a domain window
    localparam logic [4:0] W_RST_EN   = 5'h00;
    localparam logic [4:0] W_CLK_EN   = 5'h01;
    localparam logic [4:0] W_ISO_EN   = 5'h02;
    localparam logic [4:0] W_ON_MASK  = 5'h03;
    localparam logic [4:0] W_OFF_MASK = 5'h04;
    localparam logic [4:0] W_SW_DLY   = 5'h05;
    localparam logic [4:0] W_OFF_DLY  = 5'h06;
    localparam logic [4:0] W_ON_DLY   = 5'h07;
    localparam logic [4:0] W_CMD      = 5'h08;
    localparam logic [4:0] W_STATUS   = 5'h09;
    localparam logic [4:0] W_GATES    = 5'h0C;
    localparam logic [4:0] W_PSW_ST   = 5'h0D;

    localparam int BIT_DONE = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UP_SW,
        SQ_UP_ON,
        SQ_UP_CLK,
        SQ_DN_CLK,
        SQ_DN_OFF,
        SQ_DN_SW
    } seq_t;
endpackage

// File: rtl/pwr_seq_decode.sv
// Module: pwr_seq_decode
// Splits a byte address into domain index and word index, and produces one
// write strobe per domain. Assumes NUM_DOM >= 2 and ADDR_W = idx bits + 7.
module pwr_seq_decode #(
    parameter int NUM_DOM = 3,
    parameter int ADDR_W  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_DOM-1:0]   dom_wr,
    output logic [4:0]           word_idx,
    output logic [ADDR_W-8:0]    dom_idx,
    output logic                 hit
);
    import pwr_seq_pkg::*;

    assign dom_idx  = bus_addr[ADDR_W-1:WIN_BITS];
    assign word_idx = bus_addr[WIN_BITS-1:2];

    // address is word aligned and falls inside an existing window
    always_comb begin
        hit = (bus_addr[1:0] == 2'b00) && (int'(dom_idx) < NUM_DOM);
    end

    // one write strobe for the addressed domain
    always_comb begin
        for (int k = 0; k < NUM_DOM; k++) begin
            dom_wr[k] = bus_en && bus_we && hit && (int'(dom_idx) == k);
        end
    end

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dom_wr)); // R1
endmodule

// File: rtl/pwr_seq_domain.sv
// Module: pwr_seq_domain
// One power domain: its configuration registers, its command/status
// handshake and the sequencer that orders switch, isolation, clock and
// reset. Assumes software issues commands only while busy is low; a
// command written while busy is dropped.
module pwr_seq_domain #(
    parameter int PSW_W = 4,
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        word_idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [PSW_W-1:0]  psw_ack,
    output logic              gate_rst_n,
    output logic              gate_clk_en,
    output logic              gate_iso_rel,
    output logic [PSW_W-1:0]  psw_en
);
    import pwr_seq_pkg::*;

    localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(2);
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    logic              en_rst, en_clk, en_iso;
    logic [PSW_W-1:0]  on_mask, off_mask;
    logic [DLY_W-1:0]  sw_dly, off_dly, on_dly;
    logic [1:0]        cur_state;
    logic              done;
    logic              busy;
    logic [DLY_W-1:0]  cnt;
    seq_t              seq;

    logic              cmd_go;
    logic [1:0]        cmd_tgt;
    logic              clr_done;
    logic              cnt_last;

    // busy whenever the sequencer is away from idle
    assign busy = (seq != SQ_IDLE);

    // a command counts only as an exact 1 or 2 while idle
    always_comb begin
        cmd_go  = wr_en && (word_idx == W_CMD) && !busy &&
                  ((wdata == 32'd1) || (wdata == 32'd2));
        cmd_tgt = wdata[1:0];
    end

    // write-one-to-clear of the completion flag
    assign clr_done = wr_en && (word_idx == W_STATUS) && wdata[BIT_DONE];

    // final cycle of a programmed wait (0 and 1 both end here)
    assign cnt_last = (cnt <= DLY_ONE);

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_rst   <= 1'b1;
            en_clk   <= 1'b1;
            en_iso   <= 1'b1;
            on_mask  <= '1;
            off_mask <= '0;
            sw_dly   <= DLY_RST;
            off_dly  <= DLY_RST;
            on_dly   <= DLY_RST;
        end else if (wr_en) begin
            case (word_idx)
                W_RST_EN:   en_rst   <= wdata[0];
                W_CLK_EN:   en_clk   <= wdata[0];
                W_ISO_EN:   en_iso   <= wdata[0];
                W_ON_MASK:  on_mask  <= wdata[PSW_W-1:0];
                W_OFF_MASK: off_mask <= wdata[PSW_W-1:0];
                W_SW_DLY:   sw_dly   <= wdata[DLY_W-1:0];
                W_OFF_DLY:  off_dly  <= wdata[DLY_W-1:0];
                W_ON_DLY:   on_dly   <= wdata[DLY_W-1:0];
                default: ;
            endcase
        end
    end

    // sequencer: steps gates in order and maintains state and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq          <= SQ_IDLE;
            cur_state    <= ST_OFF;
            done         <= 1'b0;
            cnt          <= '0;
            gate_rst_n   <= 1'b0;
            gate_clk_en  <= 1'b0;
            gate_iso_rel <= 1'b0;
            psw_en       <= '0;
        end else begin
            if (clr_done) begin
                done <= 1'b0;
            end
            case (seq)
                SQ_IDLE: begin
                    if (cmd_go) begin
                        if (cmd_tgt == cur_state) begin
                            done <= 1'b1;
                        end else if (cmd_tgt == ST_ON) begin
                            psw_en <= on_mask;
                            cnt    <= sw_dly;
                            seq    <= SQ_UP_SW;
                        end else begin
                            gate_rst_n <= 1'b0;
                            seq        <= SQ_DN_CLK;
                        end
                    end
                end
                SQ_UP_SW: begin
                    if (cnt_last) begin
                        gate_iso_rel <= en_iso;
                        cnt          <= on_dly;
                        seq          <= SQ_UP_ON;
                    end else begin
                        cnt <= cnt - DLY_ONE;
                    end
                end
                SQ_UP_ON: begin
                    if (cnt_last) begin
                        gate_clk_en <= en_clk;
                        seq         <= SQ_UP_CLK;
                    end else begin
                        cnt <= cnt - DLY_ONE;
                    end
                end
                SQ_UP_CLK: begin
                    gate_rst_n <= en_rst;
                    cur_state  <= ST_ON;
                    done       <= 1'b1;
                    seq        <= SQ_IDLE;
                end
                SQ_DN_CLK: begin
                    gate_clk_en <= 1'b0;
                    cnt         <= off_dly;
                    seq         <= SQ_DN_OFF;
                end
                SQ_DN_OFF: begin
                    if (cnt_last) begin
                        gate_iso_rel <= 1'b0;
                        cnt          <= sw_dly;
                        seq          <= SQ_DN_SW;
                    end else begin
                        cnt <= cnt - DLY_ONE;
                    end
                end
                SQ_DN_SW: begin
                    if (cnt_last) begin
                        psw_en    <= off_mask;
                        cur_state <= ST_OFF;
                        done      <= 1'b1;
                        seq       <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - DLY_ONE;
                    end
                end
                default: seq <= SQ_IDLE;
            endcase
        end
    end

    // register read mux for this window
    always_comb begin
        case (word_idx)
            W_RST_EN:   rdata = {31'd0, en_rst};
            W_CLK_EN:   rdata = {31'd0, en_clk};
            W_ISO_EN:   rdata = {31'd0, en_iso};
            W_ON_MASK:  rdata = 32'(on_mask);
            W_OFF_MASK: rdata = 32'(off_mask);
            W_SW_DLY:   rdata = 32'(sw_dly);
            W_OFF_DLY:  rdata = 32'(off_dly);
            W_ON_DLY:   rdata = 32'(on_dly);
            W_STATUS:   rdata = {14'd0, cur_state, 12'd0, busy, 1'b0, done, 1'b0};
            W_GATES:    rdata = {29'd0, gate_iso_rel, gate_clk_en, gate_rst_n};
            W_PSW_ST:   rdata = 32'(psw_ack);
            default:    rdata = 32'd0;
        endcase
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ON) || (cur_state == ST_OFF)); // R2
    AST_ISO_MID_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_iso_rel) |-> busy && (cur_state == ST_OFF)); // R4
    AST_RST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_rst_n) |-> (cur_state == ST_ON) && !busy && done); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_OFF) && !busy |-> !gate_rst_n && !gate_clk_en && !gate_iso_rel); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_SAME_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go && (cmd_tgt == cur_state) |=> !busy && done); // R7
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Module: pwr_seq_ctrl (top)
// Register-bus front end plus one sequencer per power domain. Reads are
// combinational on bus_addr; writes take effect at the clock edge where
// bus_en and bus_we are high. Assumes NUM_DOM >= 2.
module pwr_seq_ctrl #(
    parameter int NUM_DOM = 3,
    parameter int PSW_W   = 4,
    parameter int DLY_W   = 8,
    parameter int ADDR_W  = $clog2(NUM_DOM) + 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [NUM_DOM-1:0]        dom_rst_n,
    output logic [NUM_DOM-1:0]        dom_clk_en,
    output logic [NUM_DOM-1:0]        dom_iso_rel,
    output logic [NUM_DOM*PSW_W-1:0]  dom_psw_en,
    input  logic [NUM_DOM*PSW_W-1:0]  dom_psw_ack
);
    localparam int IDX_W = ADDR_W - 7;

    logic [NUM_DOM-1:0] dom_wr;
    logic [4:0]         word_idx;
    logic [IDX_W-1:0]   dom_idx;
    logic               hit;
    logic [31:0]        dom_rd [NUM_DOM];

    pwr_seq_decode #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .dom_wr   (dom_wr),
        .word_idx (word_idx),
        .dom_idx  (dom_idx),
        .hit      (hit)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        pwr_seq_domain #(.PSW_W(PSW_W), .DLY_W(DLY_W)) u_dom (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (dom_wr[g]),
            .word_idx     (word_idx),
            .wdata        (bus_wdata),
            .rdata        (dom_rd[g]),
            .psw_ack      (dom_psw_ack[g*PSW_W +: PSW_W]),
            .gate_rst_n   (dom_rst_n[g]),
            .gate_clk_en  (dom_clk_en[g]),
            .gate_iso_rel (dom_iso_rel[g]),
            .psw_en       (dom_psw_en[g*PSW_W +: PSW_W])
        );
    end

    // select read data of the addressed window, zero elsewhere
    always_comb begin
        bus_rdata = 32'd0;
        for (int k = 0; k < NUM_DOM; k++) begin
            if (hit && (dom_idx == IDX_W'(k))) begin
                bus_rdata = dom_rd[k];
            end
        end
    end
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
    localparam int ND = 3;
    localparam int PW = 4;
    localparam int AW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [ND-1:0] dom_rst_n, dom_clk_en, dom_iso_rel;
    logic [ND*PW-1:0] dom_psw_en, dom_psw_ack, ack_d1;

    int checks = 0, errors = 0;
    logic [1:0] m_state [ND];
    logic [2:0] m_gates [ND];   // {iso, clk, rst}
    logic [PW-1:0] m_psw [ND];

    pwr_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dom_rst_n(dom_rst_n), .dom_clk_en(dom_clk_en), .dom_iso_rel(dom_iso_rel),
        .dom_psw_en(dom_psw_en), .dom_psw_ack(dom_psw_ack)
    );

    always #5 clk = ~clk;

    // ideal switch acknowledge: two-cycle echo of the enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d1 <= '0;
            dom_psw_ack <= '0;
        end else begin
            ack_d1 <= dom_psw_en;
            dom_psw_ack <= ack_d1;
        end
    end

    function automatic logic [31:0] stat(logic [1:0] st, logic b, logic d);
        return {14'd0, st, 12'd0, b, 1'b0, d, 1'b0};
    endfunction
    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic logic [AW-1:0] adr(int d, int off);
        return AW'(d * 128 + off);
    endfunction

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic gates_of(int d, output logic [2:0] g);
        g = {dom_iso_rel[d], dom_clk_en[d], dom_rst_n[d]};
    endtask

    task automatic chk_others(int d, string req);
        logic [2:0] g;
        for (int k = 0; k < ND; k++) begin
            if (k != d) begin
                gates_of(k, g);
                chk(req, {25'd0, dom_psw_en[k*PW +: PW], g}, {25'd0, m_psw[k], m_gates[k]});
            end
        end
    endtask

    // power-up with full cycle-by-cycle check; optional mid-sequence command
    task automatic power_up(int d, int sw, int on, logic [PW-1:0] msk, bit interfere);
        int s, o, t;
        logic [2:0] g, e;
        logic [31:0] v;
        wr(adr(d, 'h14), sw);
        wr(adr(d, 'h1c), on);
        wr(adr(d, 'h0c), 32'(msk));
        wr(adr(d, 'h24), 32'h2);
        s = eff(sw); o = eff(on); t = s + o + 1;
        wr(adr(d, 'h20), 32'd1);
        for (int j = 0; j <= t; j++) begin
            gates_of(d, g);
            e = {(j >= s), (j >= s + o), (j >= t)};
            chk(interfere ? "R8 up gates" : "R4 R9 up gates", {29'd0, g}, {29'd0, e});
            chk("R4 switch mask", 32'(dom_psw_en[d*PW +: PW]), 32'(msk));
            chk_others(d, "R12 other domains");
            if (j == 0) begin
                rd(adr(d, 'h24), v);
                chk("R4 busy during up", v, stat(2'd2, 1'b1, 1'b0));
            end
            if (j < t) begin
                if (j == 1 && interfere) wr(adr(d, 'h20), 32'd2);
                else @(negedge clk);
            end
        end
        rd(adr(d, 'h24), v);
        chk(interfere ? "R8 end status" : "R4 end status", v, stat(2'd1, 1'b0, 1'b1));
        m_state[d] = 2'd1; m_gates[d] = 3'b111; m_psw[d] = msk;
    endtask

    task automatic power_down(int d, int sw, int off, logic [PW-1:0] omsk);
        int s, f, t;
        logic [2:0] g, e;
        logic [31:0] v;
        wr(adr(d, 'h18), off);
        wr(adr(d, 'h10), 32'(omsk));
        wr(adr(d, 'h24), 32'h2);
        s = eff(sw); f = eff(off); t = 1 + f + s;
        wr(adr(d, 'h20), 32'd2);
        for (int j = 0; j <= t; j++) begin
            gates_of(d, g);
            e = {(j < 1 + f), (j < 1), 1'b0};
            chk("R5 down gates", {29'd0, g}, {29'd0, e});
            chk("R5 switch mask", 32'(dom_psw_en[d*PW +: PW]), 32'((j >= t) ? omsk : m_psw[d]));
            chk_others(d, "R12 other domains");
            if (j < t) @(negedge clk);
        end
        rd(adr(d, 'h24), v);
        chk("R5 end status", v, stat(2'd2, 1'b0, 1'b1));
        m_state[d] = 2'd2; m_gates[d] = 3'b000; m_psw[d] = omsk;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0] g;
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        for (int k = 0; k < ND; k++) begin
            m_state[k] = 2'd2; m_gates[k] = 3'b000; m_psw[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        for (int k = 0; k < ND; k++) begin
            rd(adr(k, 'h24), v);
            chk("R2 reset status", v, 32'h0002_0000);
        end
        chk("R2 reset outputs", {17'd0, dom_psw_en, dom_iso_rel, dom_clk_en, dom_rst_n}, 32'd0);
        rd(adr(1, 'h0c), v);
        chk("R10 on mask reset", v, 32'hF);
        rd(adr(2, 'h04), v);
        chk("R11 enable reset", v, 32'd1);

        // windows and decode
        rd(AW'(9'h180), v);
        chk("R1 out of range", v, 32'd0);
        wr(adr(1, 'h14), 32'd5);
        rd(adr(1, 'h14), v);
        chk("R10 readback", v, 32'd5);
        rd(adr(0, 'h14), v);
        chk("R1 no cross write d0", v, 32'd2);
        rd(adr(2, 'h14), v);
        chk("R1 no cross write d2", v, 32'd2);

        // invalid commands
        wr(adr(1, 'h20), 32'd3);
        wr(adr(1, 'h20), 32'd0);
        @(negedge clk);
        rd(adr(1, 'h24), v);
        chk("R3 invalid ignored", v, stat(2'd2, 1'b0, 1'b0));
        chk("R3 outputs still", {29'd0, dom_iso_rel[1], dom_clk_en[1], dom_rst_n[1]}, 32'd0);

        // zero delays
        power_up(0, 0, 0, 4'h3, 1'b0);
        power_down(0, 0, 0, 4'h0);

        // random sequences
        for (int it = 0; it < 8; it++) begin
            int d, sw, on, off;
            logic [PW-1:0] msk, omsk;
            d = int'($urandom % ND);
            sw = int'($urandom % 6); on = int'($urandom % 6); off = int'($urandom % 6);
            msk = PW'($urandom) | 4'h1;
            omsk = PW'($urandom % 4);
            power_up(d, sw, on, msk, 1'b0);
            rd(adr(d, 'h30), v);
            chk("R10 gate status", v, 32'h7);
            repeat (3) @(negedge clk);
            rd(adr(d, 'h34), v);
            chk("R10 switch ack", v, 32'(msk));
            wr(adr(d, 'h24), 32'h8);
            rd(adr(d, 'h24), v);
            chk("R6 sticky", v, stat(2'd1, 1'b0, 1'b1));
            wr(adr(d, 'h24), 32'h2);
            rd(adr(d, 'h24), v);
            chk("R6 cleared", v, stat(2'd1, 1'b0, 1'b0));
            wr(adr(d, 'h20), 32'd1);
            rd(adr(d, 'h24), v);
            chk("R7 same state", v, stat(2'd1, 1'b0, 1'b1));
            gates_of(d, g);
            chk("R7 outputs kept", {25'd0, dom_psw_en[d*PW +: PW], g}, {25'd0, msk, 3'b111});
            power_down(d, sw, off, omsk);
        end

        // command while busy
        power_up(2, 5, 5, 4'h9, 1'b1);
        power_down(2, 5, 1, 4'h0);

        // clock step disabled
        wr(adr(1, 'h04), 32'd0);
        wr(adr(1, 'h20), 32'd1);
        repeat (20) @(negedge clk);
        rd(adr(1, 'h30), v);
        chk("R11 clock step off", v, 32'h5);
        rd(adr(1, 'h24), v);
        chk("R11 state on", v, stat(2'd1, 1'b0, 1'b1));
        wr(adr(1, 'h04), 32'd1);
        wr(adr(1, 'h10), 32'd0);
        wr(adr(1, 'h20), 32'd2);
        repeat (20) @(negedge clk);
        rd(adr(1, 'h24), v);
        chk("R5 back off", v, stat(2'd2, 1'b0, 1'b1));

        report();
        $finish;
    end
endmodule